// File: doc/BRIEF.md
# CAM validity and address controller

This block is the command decoder and state keeper for a small content-addressable memory. It holds one active-low validity bit per location (LOW = valid, HIGH = empty), an address register that points at one location, a page-address field used when several devices are loaded one after another, and an active-low full flag. Empty locations take no part in comparisons and are the candidates for the next write to a free slot. The match vector from the previous comparison comes in from the compare array. The compare array and any link between devices are not part of this block.

A command is a 12-bit word. Only its low 6 bits are decoded. It is taken on a rising clock edge while the data/command select is LOW and the access select is HIGH. The write strobe is active low. A command can mark the location under the address register valid or empty, or read its validity bit. It can also empty the lowest-addressed match or every match, step the address register up or down, load the page field, drive the full flag, or reset the whole state. Two outputs are driven all the time: the lowest-addressed empty location, and a flag that is set when no location is empty.

Top module: `cam_valid_ctrl`

## Requirements
- R1: A command takes effect only on a clock edge where data_sel_i is LOW and acc_sel_i is HIGH. At any other edge no state changes. Bits 11:6 of instr_i are ignored.
- R2: Code 6'b100000 with wr_ni LOW makes valid_n_o[addr_o] LOW (valid).
- R3: Code 6'b100000 with wr_ni HIGH is a read. One edge later rd_data_o[0] holds valid_n_o[addr_o] and bits 31:1 are zero. No other state changes.
- R4: Code 6'b100001 with wr_ni LOW makes valid_n_o[addr_o] HIGH (empty).
- R5: Code 6'b100010 with wr_ni LOW makes HIGH the validity bit at the lowest set index of match_i. If match_i is all zero, nothing changes.
- R6: Code 6'b100011 with wr_ni LOW makes HIGH the validity bit of every location whose match_i bit is set. All other bits keep their value.
- R7: Code 6'b100100 increments addr_o and code 6'b100101 decrements it, both with wr_ni LOW. The count wraps modulo DEPTH, so DEPTH-1 steps up to 0 and 0 steps down to DEPTH-1.
- R8: Code 6'b111100 with wr_ni LOW loads data_i[3:0] into page_o and drives full_no LOW. Code 6'b111101 with wr_ni LOW drives full_no HIGH.
- R9: Code 6'b111111 with wr_ni LOW, and rst_ni LOW, both return the block to its reset state: every validity bit HIGH, addr_o = 0, page_o = 0, full_no HIGH and rd_data_o = 0.
- R10: Any other code, and any code except 6'b100000 given with wr_ni HIGH, leaves every piece of state unchanged.
- R11: free_addr_o is the lowest index whose validity bit is HIGH. none_free_o is HIGH only when every bit is LOW, and free_addr_o is 0 in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 12 | Command word; only bits 5:0 are decoded |
| wr_ni | input | 1 | Write strobe, active low |
| data_sel_i | input | 1 | LOW selects a command cycle |
| acc_sel_i | input | 1 | HIGH selects a validity/address access |
| data_i | input | 32 | Data lines; bits 3:0 feed the page load |
| match_i | input | 16 | Match vector from the previous comparison |
| rd_data_o | output | 32 | Result of a validity read |
| valid_n_o | output | 16 | Validity bits, LOW = valid |
| addr_o | output | 4 | Address register |
| page_o | output | 4 | Page-address field |
| full_no | output | 1 | Full flag, active low |
| free_addr_o | output | 4 | Lowest-addressed empty location |
| none_free_o | output | 1 | HIGH when no location is empty |

## Verification
The assertions assume that match_i is steady around each clock edge. They also assume match_i already reflects the comparison the clear commands refer to, so that the clear result can be related to the match value sampled one edge earlier. The bench changes every input only on falling edges. It sets match_i before the command that uses it and keeps it there across that edge. Between commands it drops acc_sel_i, so every idle cycle also exercises the ignore path of R1.

// File: rtl/cam_ctrl_pkg.sv
package cam_ctrl_pkg;
  localparam int unsigned CODE_W = 6;

  localparam logic [CODE_W-1:0] C_VALID   = 6'b100000;
  localparam logic [CODE_W-1:0] C_EMPTY   = 6'b100001;
  localparam logic [CODE_W-1:0] C_CLR_HPM = 6'b100010;
  localparam logic [CODE_W-1:0] C_CLR_ALL = 6'b100011;
  localparam logic [CODE_W-1:0] C_INC     = 6'b100100;
  localparam logic [CODE_W-1:0] C_DEC     = 6'b100101;
  localparam logic [CODE_W-1:0] C_LD_PAGE = 6'b111100;
  localparam logic [CODE_W-1:0] C_FULL_HI = 6'b111101;
  localparam logic [CODE_W-1:0] C_RESET   = 6'b111111;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_SET_VALID,
    OP_READ,
    OP_SET_EMPTY,
    OP_CLR_HPM,
    OP_CLR_ALL,
    OP_INC,
    OP_DEC,
    OP_LD_PAGE,
    OP_FULL_HI,
    OP_RESET
  } op_e;
endpackage

// File: rtl/cam_op_dec.sv
module cam_op_dec
  import cam_ctrl_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              wr_ni,
  input  logic              data_sel_i,
  input  logic              acc_sel_i,
  output op_e               op_o
);
  logic accept;
  assign accept = !data_sel_i && acc_sel_i;

  always_comb begin
    op_o = OP_NONE;
    if (accept) begin
      if (wr_ni) begin
        if (code_i == C_VALID) op_o = OP_READ;
      end else begin
        unique case (code_i)
          C_VALID:   op_o = OP_SET_VALID;
          C_EMPTY:   op_o = OP_SET_EMPTY;
          C_CLR_HPM: op_o = OP_CLR_HPM;
          C_CLR_ALL: op_o = OP_CLR_ALL;
          C_INC:     op_o = OP_INC;
          C_DEC:     op_o = OP_DEC;
          C_LD_PAGE: op_o = OP_LD_PAGE;
          C_FULL_HI: op_o = OP_FULL_HI;
          C_RESET:   op_o = OP_RESET;
          default:   op_o = OP_NONE; // reserved: no effect
        endcase
      end
    end
  end

  always_comb begin
    if (!accept) a_r1_gate_none : assert (op_o == OP_NONE);
  end
endmodule

// File: rtl/cam_first_one.sv
module cam_first_one #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          hit_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign hit_o = |vec_i;

  // R11: reported index is set and nothing below it is set
  always_comb begin
    if (hit_o) begin
      a_r11_idx_set : assert (vec_i[idx_o]);
      a_r11_lowest  : assert ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0);
    end else begin
      a_r11_none_zero : assert (idx_o == '0);
    end
  end
endmodule

// File: rtl/cam_valid_bank.sv
module cam_valid_bank
  import cam_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] ar_i,
  input  logic [DEPTH-1:0]  match_i,
  input  logic [ADDR_W-1:0] hpm_idx_i,
  input  logic              hpm_hit_i,
  output logic [DEPTH-1:0]  valid_n_o
);
  logic [DEPTH-1:0] valid_n_q, valid_n_d;

  always_comb begin
    valid_n_d = valid_n_q;
    unique case (op_i)
      OP_SET_VALID: valid_n_d[ar_i] = 1'b0;
      OP_SET_EMPTY: valid_n_d[ar_i] = 1'b1;
      OP_CLR_HPM:   if (hpm_hit_i) valid_n_d[hpm_idx_i] = 1'b1;
      OP_CLR_ALL:   valid_n_d = valid_n_q | match_i;
      OP_RESET:     valid_n_d = '1;
      default:      valid_n_d = valid_n_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_n_q <= '1;
    else         valid_n_q <= valid_n_d;
  end

  assign valid_n_o = valid_n_q;

  a_r2_set_valid : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SET_VALID |=> valid_n_q[$past(ar_i)] == 1'b0);
  a_r4_set_empty : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SET_EMPTY |=> valid_n_q[$past(ar_i)] == 1'b1);
  a_r5_no_match : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR_HPM && match_i == '0) |=> $stable(valid_n_q));
  a_r5_one_bit : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLR_HPM |=> $countones(valid_n_q ^ $past(valid_n_q)) <= 1);
  a_r6_all_match : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLR_ALL |=> (valid_n_q == ($past(valid_n_q) | $past(match_i))));
  a_r9_all_empty : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_RESET |=> valid_n_q == '1);
endmodule

// File: rtl/cam_valid_ctrl.sv
module cam_valid_ctrl
  import cam_ctrl_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned INSTR_W = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PAGE_W  = 4,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               wr_ni,
  input  logic               data_sel_i,
  input  logic               acc_sel_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [DEPTH-1:0]   match_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [DEPTH-1:0]   valid_n_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic               full_no,
  output logic [ADDR_W-1:0]  free_addr_o,
  output logic               none_free_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic unused_hi;
  assign unused_hi = ^{instr_i[INSTR_W-1:CODE_W], data_i[DATA_W-1:PAGE_W]};

  op_e               op;
  logic [ADDR_W-1:0] ar_q, hpm_idx, free_idx;
  logic [PAGE_W-1:0] page_q;
  logic              full_nq, hpm_hit, free_hit;
  logic [DATA_W-1:0] rd_q;
  logic [DEPTH-1:0]  valid_n;

  cam_op_dec u_dec (
    .code_i     (instr_i[CODE_W-1:0]),
    .wr_ni      (wr_ni),
    .data_sel_i (data_sel_i),
    .acc_sel_i  (acc_sel_i),
    .op_o       (op)
  );

  cam_first_one #(.N(DEPTH), .IW(ADDR_W)) u_hpm (
    .vec_i (match_i),
    .idx_o (hpm_idx),
    .hit_o (hpm_hit)
  );

  cam_valid_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .ar_i      (ar_q),
    .match_i   (match_i),
    .hpm_idx_i (hpm_idx),
    .hpm_hit_i (hpm_hit),
    .valid_n_o (valid_n)
  );

  cam_first_one #(.N(DEPTH), .IW(ADDR_W)) u_free (
    .vec_i (valid_n),
    .idx_o (free_idx),
    .hit_o (free_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q    <= '0;
      page_q  <= '0;
      full_nq <= 1'b1;
      rd_q    <= '0;
    end else begin
      unique case (op)
        OP_INC:     ar_q <= (ar_q == LAST) ? '0 : ar_q + 1'b1;
        OP_DEC:     ar_q <= (ar_q == '0) ? LAST : ar_q - 1'b1;
        OP_LD_PAGE: begin
          page_q  <= data_i[PAGE_W-1:0];
          full_nq <= 1'b0;
        end
        OP_FULL_HI: full_nq <= 1'b1;
        OP_READ:    rd_q <= {{(DATA_W-1){1'b0}}, valid_n[ar_q]};
        OP_RESET: begin
          ar_q    <= '0;
          page_q  <= '0;
          full_nq <= 1'b1;
          rd_q    <= '0;
        end
        default: ;
      endcase
    end
  end

  assign rd_data_o   = rd_q;
  assign valid_n_o   = valid_n;
  assign addr_o      = ar_q;
  assign page_o      = page_q;
  assign full_no     = full_nq;
  assign free_addr_o = free_idx;
  assign none_free_o = !free_hit;

  a_r1_ignored : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_sel_i || !acc_sel_i) |=> ($stable(valid_n) && $stable(ar_q) && $stable(page_q)
                                    && $stable(full_nq) && $stable(rd_q)));
  a_r10_no_effect : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_NONE |=> ($stable(valid_n) && $stable(ar_q) && $stable(page_q) && $stable(full_nq)));
  a_r3_read_data : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_READ |=> (rd_q[DATA_W-1:1] == '0 && rd_q[0] == $past(valid_n[ar_q]) && $stable(valid_n)));
  a_r7_inc : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_INC |=> ar_q == (($past(ar_q) == LAST) ? '0 : $past(ar_q) + 1'b1));
  a_r7_dec : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_DEC |=> ar_q == (($past(ar_q) == '0) ? LAST : $past(ar_q) - 1'b1));
  a_r8_page : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_LD_PAGE |=> (!full_nq && page_q == $past(data_i[PAGE_W-1:0])));
  a_r8_full_hi : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_FULL_HI |=> full_nq);
  a_r9_reset_cmd : assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_RESET |=> (ar_q == '0 && page_q == '0 && full_nq && rd_q == '0));
endmodule

// File: tb/cam_valid_ctrl_bench.sv
module cam_valid_ctrl_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] instr = '0;
  logic        wr_n = 1'b1, dsel = 1'b1, asel = 1'b0;
  logic [31:0] data = '0;
  logic [15:0] match = '0;
  logic [31:0] rd_data;
  logic [15:0] valid_n;
  logic [3:0]  addr, page, free_addr;
  logic        full_n, none_free;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  logic [15:0] e_v;
  logic [3:0]  e_ar, e_page;
  logic        e_full;

  always #5 clk = ~clk;

  cam_valid_ctrl u_cam_valid_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .wr_ni(wr_n),
    .data_sel_i(dsel), .acc_sel_i(asel), .data_i(data), .match_i(match),
    .rd_data_o(rd_data), .valid_n_o(valid_n), .addr_o(addr), .page_o(page),
    .full_no(full_n), .free_addr_o(free_addr), .none_free_o(none_free)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(string req);
    logic [3:0] ef = '0;
    bit found = 1'b0;
    for (int i = 0; i < DEPTH; i++) if (e_v[i] && !found) begin ef = 4'(i); found = 1'b1; end
    chk(req, "valid_n", 32'(valid_n), 32'(e_v));
    chk(req, "addr", 32'(addr), 32'(e_ar));
    chk(req, "page", 32'(page), 32'(e_page));
    chk(req, "full_n", 32'(full_n), 32'(e_full));
    chk(req, "free_addr", 32'(free_addr), 32'(ef));
    chk(req, "none_free", 32'(none_free), 32'(!found));
  endtask

  // one command edge, then back to idle; returns on the falling edge after it
  task automatic cmd(logic [5:0] code, logic w = 1'b0, logic [5:0] hi = '0,
                     logic ds = 1'b0, logic as = 1'b1, logic [31:0] d = '0);
    @(negedge clk);
    instr = {hi, code}; wr_n = w; dsel = ds; asel = as; data = d;
    @(negedge clk);
    asel = 1'b0; dsel = 1'b1; wr_n = 1'b1;
  endtask

  task automatic step_to(logic [3:0] a);
    while (e_ar != a) begin
      cmd(6'b100100);
      e_ar = e_ar + 1'b1;
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    e_v = '1; e_ar = '0; e_page = '0; e_full = 1'b1;
    chk_state("R9");
    chk("R9", "rd_data", rd_data, '0);
  endtask

  task automatic t_set_valid;
    for (int i = 0; i < 3; i++) begin
      step_to(4'(i));
      cmd(6'b100000);
      e_v[i] = 1'b0;
    end
    chk_state("R2");
  endtask

  task automatic t_read;
    step_to(4'd1);
    cmd(6'b100000, 1'b1);
    chk("R3", "rd valid", rd_data, 32'h0);
    chk_state("R3");
    step_to(4'd3);
    cmd(6'b100000, 1'b1);
    chk("R3", "rd empty", rd_data, 32'h1);
    chk_state("R3");
  endtask

  task automatic t_gate;
    step_to(4'd4);
    cmd(6'b100000, 1'b0, 6'h00, 1'b1, 1'b1);
    chk_state("R1");
    cmd(6'b100000, 1'b0, 6'h00, 1'b0, 1'b0);
    chk_state("R1");
    cmd(6'b100100, 1'b0, 6'h00, 1'b1, 1'b1);
    chk_state("R1");
    cmd(6'b100000, 1'b0, 6'h3e);
    e_v[4] = 1'b0;
    chk_state("R1");
  endtask

  task automatic t_set_empty;
    step_to(4'd1);
    cmd(6'b100001);
    e_v[1] = 1'b1;
    chk_state("R4");
  endtask

  task automatic t_hpm;
    step_to(4'd9);
    cmd(6'b100000);
    e_v[9] = 1'b0;
    match = 16'h0211;
    cmd(6'b100010);
    e_v[0] = 1'b1;
    chk_state("R5");
    match = 16'h0000;
    cmd(6'b100010);
    chk_state("R5");
    match = 16'h0210;
    cmd(6'b100010);
    e_v[4] = 1'b1;
    chk_state("R5");
  endtask

  task automatic t_clr_all;
    for (int i = 10; i < 14; i++) begin
      step_to(4'(i));
      cmd(6'b100000);
      e_v[i] = 1'b0;
    end
    match = 16'h2a04;
    cmd(6'b100011);
    e_v = e_v | 16'h2a04;
    chk_state("R6");
    match = '0;
  endtask

  task automatic t_wrap;
    step_to(4'd15);
    cmd(6'b100100);
    e_ar = 4'd0;
    chk_state("R7");
    cmd(6'b100101);
    e_ar = 4'd15;
    chk_state("R7");
    cmd(6'b100101);
    e_ar = 4'd14;
    chk_state("R7");
  endtask

  task automatic t_page;
    cmd(6'b111100, 1'b0, 6'h00, 1'b0, 1'b1, 32'hffff_ffa5);
    e_page = 4'h5; e_full = 1'b0;
    chk_state("R8");
    cmd(6'b111101);
    e_full = 1'b1;
    chk_state("R8");
  endtask

  task automatic t_reserved;
    cmd(6'b111100, 1'b0, 6'h00, 1'b0, 1'b1, 32'h0000_000c);
    e_page = 4'hc; e_full = 1'b0;
    cmd(6'b100110);
    chk_state("R10");
    cmd(6'b000000);
    chk_state("R10");
    cmd(6'b111110);
    chk_state("R10");
    cmd(6'b100100, 1'b1);
    chk_state("R10");
    cmd(6'b111111, 1'b1);
    chk_state("R10");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) begin
      step_to(4'(i));
      cmd(6'b100000);
      e_v[i] = 1'b0;
    end
    chk_state("R11");
    step_to(4'd7);
    cmd(6'b100001);
    e_v[7] = 1'b1;
    chk_state("R11");
  endtask

  task automatic t_reset_cmd;
    cmd(6'b100000, 1'b1);
    chk("R3", "rd empty", rd_data, 32'h1);
    cmd(6'b111111, 1'b0, 6'h15);
    e_v = '1; e_ar = '0; e_page = '0; e_full = 1'b1;
    chk_state("R9");
    chk("R9", "rd_data", rd_data, '0);
  endtask

  initial begin
    t_reset;
    t_set_valid;
    t_read;
    t_gate;
    t_set_empty;
    t_hpm;
    t_clr_all;
    t_wrap;
    t_page;
    t_reserved;
    t_full;
    t_reset_cmd;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule